// File: doc/BRIEF.md
# Transceiver Supply Enable Controller

This block holds the control logic for the supply rail that feeds a bus transmitter. It switches the supply on by itself when the bus shows activity or when the transceiver is in Active mode and not held off by the host. It also switches the supply on when the host sets a manual-enable bit, so the rail can power other loads while the transceiver is idle. After power-up the output must rise within a fixed startup window. A short circuit while the supply is enabled ends the attempt. Either failure switches the supply off, reports the failure and changes the host's control bits.

After a fault the supply stays off until one of four reactivation events occurs. These are: the host clears the transceiver-off bit while in Active mode; a bus wake-up arrives while not in Active mode; the host sets the manual-enable bit; or the transceiver enters Active mode. Other demand is ignored. Once the supply is running it stays on until a fault, even when the demand goes away. The host sees the supply state as a "supply OK" diagnosis bit and as a sticky, maskable interrupt flag.

Top module: `xcvr_supply_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `supply_en_o`, `supply_ok_o`, `man_en_o`, `xcvr_off_o`, `irq_pending_o` and `irq_o` are all 0, and the controller is in the Off state.
- R2: In the Off state, the supply turns on at the next clock edge when any of these is 1: `bus_activity_i`; `xcvr_active_i` with `xcvr_off_o` at 0; or `man_en_o`. The register values used are the ones held before that edge.
- R3: While the supply is starting, the first edge at which `out_low_i` is 0 moves the controller to On, and `supply_ok_o` is 1 from then on. `supply_ok_o` is never 1 while `supply_en_o` is 0.
- R4: If `out_low_i` stays 1 for `WINDOW_CYCLES` clock edges after the edge that enabled the supply, the supply is disabled at the last of those edges. With the default of 16, `supply_en_o` is high for exactly 16 cycles.
- R5: When `short_i` is 1 while `supply_en_o` is 1, the supply is disabled at the next edge.
- R6: On a fault (timeout or short), at the same edge: `supply_ok_o` becomes 0, `xcvr_off_o` becomes 1, `man_en_o` becomes 0 and `irq_pending_o` becomes 1. These updates win over a host write or an interrupt clear in the same cycle.
- R7: After a fault, the supply stays off under any stimulus that is not a reactivation event. This includes bus activity, a host write that does not set `man_en_o` or clear `xcvr_off_o`, and `xcvr_active_i` falling.
- R8: After a fault, each reactivation event turns the supply on at the next edge: a write with `host_xcvr_off_i`=0 while `xcvr_off_o`=1 and in Active mode; `bus_wake_i` while not in Active mode; a write with `host_man_en_i`=1 while `man_en_o`=0; or `xcvr_active_i` rising.
- R9: `irq_pending_o` is sticky. A cycle with `host_irq_clr_i`=1 clears it, unless a fault occurs in the same cycle. `irq_o` equals `irq_pending_o` AND the interrupt-enable bit.
- R10: Once On, the supply stays enabled, whatever the demand inputs do, until a fault.
- R11: A cycle with `host_wr_i`=1 loads `host_man_en_i`, `host_xcvr_off_i` and `host_irq_en_i` into the manual-enable, transceiver-off and interrupt-enable bits at that edge, unless a fault overrides them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_activity_i | input | 1 | Bus activity is being seen |
| bus_wake_i | input | 1 | Bus wake-up indication |
| xcvr_active_i | input | 1 | Transceiver is in Active mode |
| host_wr_i | input | 1 | Host write strobe for the control bits |
| host_man_en_i | input | 1 | Write data: manual supply enable |
| host_xcvr_off_i | input | 1 | Write data: transceiver-off control |
| host_irq_en_i | input | 1 | Write data: interrupt enable |
| host_irq_clr_i | input | 1 | Write-1-to-clear strobe for the interrupt flag |
| out_low_i | input | 1 | Comparator: supply output still held low |
| short_i | input | 1 | Comparator: short circuit on the output |
| supply_en_o | output | 1 | Regulator enable |
| supply_ok_o | output | 1 | Diagnosis: supply running |
| man_en_o | output | 1 | Manual-enable bit |
| xcvr_off_o | output | 1 | Transceiver-off bit |
| irq_pending_o | output | 1 | Sticky supply-fault interrupt flag |
| irq_o | output | 1 | Masked interrupt request |

## Verification
A fault, a reactivation event or demand from an input pin changes `supply_en_o` one edge after the stimulus. Demand from a host write takes two edges, because the Off state reads the register value. The timeout lands exactly `WINDOW_CYCLES` edges after the enabling edge. Register and flag outputs move at the edge of the write or fault. The bench drives inputs on the falling edge. At each falling edge it advances a cycle model built from the requirements, so every comparison falls half a period after the edge that made the result. The directed checks count those edges explicitly.

// File: rtl/xsup_pkg.sv
// Shared types for the transceiver supply controller.
package xsup_pkg;
    typedef enum logic [1:0] {
        SUP_OFF      = 2'd0,
        SUP_STARTING = 2'd1,
        SUP_ON       = 2'd2,
        SUP_FAULTED  = 2'd3
    } sup_state_e;
endpackage

// File: rtl/xsup_startup_timer.sv
// Startup window counter.
// Counts edges while the supply is starting and the output is still low.
// Restarts on every new enable and flags expiry on the last allowed cycle.
// Assumes WINDOW_CYCLES >= 1.
module xsup_startup_timer #(
    parameter int unsigned WINDOW_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int unsigned CW = (WINDOW_CYCLES < 2) ? 1 : $clog2(WINDOW_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count low-output cycles, saturating at the last window cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart_i)
            cnt_q <= '0;
        else if (run_i && cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expire_o = run_i && (cnt_q == LAST);

    p_cnt_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> cnt_q == '0);
endmodule

// File: rtl/xsup_wake_events.sv
// Reactivation event detector.
// Recognises the four events that may restart the supply after a fault.
// Register inputs are the values held before the current edge.
module xsup_wake_events (
    input  logic clk,
    input  logic rst_n,
    input  logic host_wr_i,
    input  logic wdata_man_i,
    input  logic wdata_off_i,
    input  logic man_en_q_i,
    input  logic off_q_i,
    input  logic xcvr_active_i,
    input  logic bus_wake_i,
    output logic reactivate_o
);
    logic active_q;
    logic ev_off_clear;
    logic ev_wake;
    logic ev_man_set;
    logic ev_active_entry;

    // Remember last cycle's mode to spot entry into Active mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= 1'b0;
        else
            active_q <= xcvr_active_i;
    end

    // Combine the four qualifying events.
    always_comb begin
        ev_off_clear    = host_wr_i && off_q_i && !wdata_off_i && xcvr_active_i;
        ev_wake         = bus_wake_i && !xcvr_active_i;
        ev_man_set      = host_wr_i && !man_en_q_i && wdata_man_i;
        ev_active_entry = xcvr_active_i && !active_q;
        reactivate_o    = ev_off_clear || ev_wake || ev_man_set || ev_active_entry;
    end

    p_entry_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xcvr_active_i) |-> reactivate_o);
endmodule

// File: rtl/xsup_host_regs.sv
// Host-visible control bits and the supply interrupt flag.
// A fault overrides any host write or clear in the same cycle.
module xsup_host_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic host_wr_i,
    input  logic wdata_man_i,
    input  logic wdata_off_i,
    input  logic wdata_ien_i,
    input  logic irq_clr_i,
    input  logic fault_i,
    output logic man_en_o,
    output logic off_o,
    output logic irq_flag_o,
    output logic irq_o
);
    logic ien_q;

    // Update control bits from host writes; fault updates take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            man_en_o <= 1'b0;
            off_o    <= 1'b0;
            ien_q    <= 1'b0;
        end else begin
            if (host_wr_i) begin
                man_en_o <= wdata_man_i;
                off_o    <= wdata_off_i;
                ien_q    <= wdata_ien_i;
            end
            if (fault_i) begin
                man_en_o <= 1'b0;
                off_o    <= 1'b1;
            end
        end
    end

    // Sticky interrupt flag, cleared by a write of 1, set by a fault.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_flag_o <= 1'b0;
        else if (fault_i)
            irq_flag_o <= 1'b1;
        else if (irq_clr_i)
            irq_flag_o <= 1'b0;
    end

    assign irq_o = irq_flag_o && ien_q;

    p_fault_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> off_o && !man_en_o && irq_flag_o);
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag_o && !irq_clr_i |=> irq_flag_o);
endmodule

// File: rtl/xcvr_supply_ctrl.sv
// Transceiver supply enable controller (top).
// Runs the Off/Starting/On/Faulted sequence for the transmitter supply.
// Comparator inputs are assumed already synchronous to clk.
module xcvr_supply_ctrl #(
    parameter int unsigned WINDOW_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_activity_i,
    input  logic bus_wake_i,
    input  logic xcvr_active_i,
    input  logic host_wr_i,
    input  logic host_man_en_i,
    input  logic host_xcvr_off_i,
    input  logic host_irq_en_i,
    input  logic host_irq_clr_i,
    input  logic out_low_i,
    input  logic short_i,
    output logic supply_en_o,
    output logic supply_ok_o,
    output logic man_en_o,
    output logic xcvr_off_o,
    output logic irq_pending_o,
    output logic irq_o
);
    import xsup_pkg::*;

    sup_state_e state_q, state_d;
    logic demand;
    logic fault;
    logic expire;
    logic reactivate;
    logic restart;

    xsup_startup_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .run_i     (state_q == SUP_STARTING && out_low_i),
        .expire_o  (expire)
    );

    xsup_wake_events i_events (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr_i     (host_wr_i),
        .wdata_man_i   (host_man_en_i),
        .wdata_off_i   (host_xcvr_off_i),
        .man_en_q_i    (man_en_o),
        .off_q_i       (xcvr_off_o),
        .xcvr_active_i (xcvr_active_i),
        .bus_wake_i    (bus_wake_i),
        .reactivate_o  (reactivate)
    );

    xsup_host_regs i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr_i   (host_wr_i),
        .wdata_man_i (host_man_en_i),
        .wdata_off_i (host_xcvr_off_i),
        .wdata_ien_i (host_irq_en_i),
        .irq_clr_i   (host_irq_clr_i),
        .fault_i     (fault),
        .man_en_o    (man_en_o),
        .off_o       (xcvr_off_o),
        .irq_flag_o  (irq_pending_o),
        .irq_o       (irq_o)
    );

    // Derive demand and fault conditions from the current state and inputs.
    always_comb begin
        demand = bus_activity_i || (xcvr_active_i && !xcvr_off_o) || man_en_o;
        fault  = (state_q == SUP_STARTING && expire) ||
                 ((state_q == SUP_STARTING || state_q == SUP_ON) && short_i);
    end

    // Next-state selection for the supply sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUP_OFF:      if (demand) state_d = SUP_STARTING;
            SUP_STARTING: if (fault) state_d = SUP_FAULTED;
                          else if (!out_low_i) state_d = SUP_ON;
            SUP_ON:       if (fault) state_d = SUP_FAULTED;
            SUP_FAULTED:  if (reactivate) state_d = SUP_STARTING;
            default:      state_d = SUP_OFF;
        endcase
        restart = (state_q != SUP_STARTING) && (state_d == SUP_STARTING);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SUP_OFF;
        else
            state_q <= state_d;
    end

    // Diagnosis bit: set on reaching On, cleared by a fault.
    always_ff @(posedge clk) begin
        if (!rst_n)
            supply_ok_o <= 1'b0;
        else if (fault)
            supply_ok_o <= 1'b0;
        else if (state_d == SUP_ON)
            supply_ok_o <= 1'b1;
    end

    assign supply_en_o = (state_q == SUP_STARTING) || (state_q == SUP_ON);

    p_ok_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        supply_ok_o |-> supply_en_o);
    p_demand_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SUP_OFF && demand |=> supply_en_o && !supply_ok_o);
    p_timeout_kills_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SUP_STARTING && expire |=> !supply_en_o);
    p_short_kills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        short_i && supply_en_o |=> !supply_en_o && !supply_ok_o);
    p_fault_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SUP_FAULTED && !reactivate |=> !supply_en_o);
    p_on_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SUP_ON && !short_i |=> supply_ok_o && supply_en_o);
endmodule

// File: tb/test_xcvr_supply_ctrl.sv
module test_xcvr_supply_ctrl;
    localparam int WIN = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_act = 0, wake = 0, active = 0, wr = 0, w_man = 0, w_off = 0, w_ien = 0;
    logic clr = 0, olow = 0, shrt = 0;
    logic en, ok, man, off, flag, irq;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // model state: 0 Off, 1 Starting, 2 On, 3 Faulted
    int m_st = 0, m_cnt = 0;
    bit m_man = 0, m_off = 0, m_ien = 0, m_flag = 0, m_actq = 0;

    always #10 clk = ~clk;

    xcvr_supply_ctrl #(.WINDOW_CYCLES(WIN)) i_xcvr_supply_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_activity_i(bus_act), .bus_wake_i(wake),
        .xcvr_active_i(active), .host_wr_i(wr), .host_man_en_i(w_man),
        .host_xcvr_off_i(w_off), .host_irq_en_i(w_ien), .host_irq_clr_i(clr),
        .out_low_i(olow), .short_i(shrt), .supply_en_o(en), .supply_ok_o(ok),
        .man_en_o(man), .xcvr_off_o(off), .irq_pending_o(flag), .irq_o(irq)
    );

    function automatic int f_next(int st, bit dem, bit flt, bit lo, bit ev);
        case (st)
            0: return dem ? 1 : 0;
            1: return flt ? 3 : (!lo ? 2 : 1);
            2: return flt ? 3 : 2;
            default: return ev ? 1 : 3;
        endcase
    endfunction

    task automatic chk(bit good, string tag, int act, int exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // advance the requirement model by one edge using the present inputs
    task automatic model_step();
        bit dem, flt, ev;
        int nst;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_man = 0; m_off = 0; m_ien = 0; m_flag = 0; m_actq = 0;
            return;
        end
        dem = bus_act || (active && !m_off) || m_man;
        flt = (m_st == 1 && olow && m_cnt == WIN - 1) || ((m_st == 1 || m_st == 2) && shrt);
        ev  = (wr && m_off && !w_off && active) || (wake && !active) ||
              (wr && !m_man && w_man) || (active && !m_actq);
        nst = f_next(m_st, dem, flt, olow, ev);
        if (m_st != 1 && nst == 1) m_cnt = 0;
        else if (m_st == 1 && olow && m_cnt != WIN - 1) m_cnt++;
        if (wr) begin m_man = w_man; m_off = w_off; m_ien = w_ien; end
        if (clr) m_flag = 0;
        if (flt) begin m_man = 0; m_off = 1; m_flag = 1; end
        m_actq = active;
        m_st = nst;
    endtask

    task automatic compare();
        chk(en == (m_st == 1 || m_st == 2), "R8 supply enable vs model", en, (m_st == 1 || m_st == 2));
        chk(ok == (m_st == 2), "R3 supply ok vs model", ok, (m_st == 2));
        chk(man == m_man, "R6 manual enable vs model", man, m_man);
        chk(off == m_off, "R6 transceiver off vs model", off, m_off);
        chk(flag == m_flag, "R9 irq flag vs model", flag, m_flag);
        chk(irq == (m_flag && m_ien), "R9 irq output vs model", irq, (m_flag && m_ien));
    endtask

    task automatic step();
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst_n = 0;
        {bus_act, wake, active, wr, w_man, w_off, w_ien, clr, olow, shrt} = '0;
        repeat (3) step();
        rst_n = 1;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        do_reset();
        // R1: reset state
        chk({en, ok, man, off, flag, irq} == 6'b0, "R1 reset outputs", {en, ok, man, off, flag, irq}, 0);

        // R11 then R2: manual enable write, start two edges later
        olow = 1;
        wr = 1; w_man = 1; w_off = 0; w_ien = 1;
        step();
        wr = 0;
        chk(man == 1, "R11 manual bit written", man, 1);
        chk(en == 0, "R2 off state reads register value", en, 0);
        step();
        chk(en == 1, "R2 manual demand starts supply", en, 1);
        // R4: timeout with output held low
        for (int i = 0; i < WIN - 1; i++) begin
            step();
            chk(en == 1, "R4 still inside window", en, 1);
        end
        step();
        chk(en == 0, "R4 window expired", en, 0);
        chk(flag == 1 && off == 1 && man == 0, "R6 fault bit updates", {flag, off, man}, 3'b110);
        chk(irq == 1, "R9 enabled interrupt raised", irq, 1);

        // R7: ignored stimuli while faulted
        bus_act = 1; wr = 1; w_man = 0; w_off = 1; w_ien = 1;
        step();
        wr = 0;
        repeat (3) begin
            step();
            chk(en == 0, "R7 faulted ignores demand", en, 0);
        end
        bus_act = 0;

        // R9: clear the flag
        clr = 1; step(); clr = 0;
        chk(flag == 0 && irq == 0, "R9 write-one clear", flag, 0);
        // R8: setting manual enable reactivates
        wr = 1; w_man = 1; w_off = 1; step(); wr = 0;
        chk(en == 1, "R8 manual set reactivates", en, 1);
        olow = 0; step();
        chk(ok == 1, "R3 output rose, supply ok", ok, 1);
        // R10: dropping demand keeps it on
        wr = 1; w_man = 0; w_off = 1; step(); wr = 0; step();
        chk(en == 1 && ok == 1, "R10 on state holds", {en, ok}, 2'b11);

        // R5 and R6: short with a colliding host write
        shrt = 1; wr = 1; w_man = 1; w_off = 0; step();
        shrt = 0; wr = 0;
        chk(en == 0, "R5 short disables", en, 0);
        chk(man == 0 && off == 1, "R6 fault wins over write", {man, off}, 2'b01);

        // R8: entering Active mode
        active = 1; step();
        chk(en == 1, "R8 active entry reactivates", en, 1);
        shrt = 1; step(); shrt = 0;
        // R8: clearing transceiver-off while active
        wr = 1; w_man = 0; w_off = 0; step(); wr = 0;
        chk(en == 1, "R8 off-bit clear in active reactivates", en, 1);
        shrt = 1; step(); shrt = 0;
        active = 0; step();
        chk(en == 0, "R7 leaving active is no event", en, 0);
        // R8: wake while not active
        wake = 1; step(); wake = 0;
        chk(en == 1, "R8 wake reactivates", en, 1);

        // R2: bus activity and active-mode demand from Off
        do_reset();
        bus_act = 1; step(); bus_act = 0;
        chk(en == 1, "R2 bus activity starts supply", en, 1);
        do_reset();
        active = 1; step();
        chk(en == 1, "R2 active mode starts supply", en, 1);

        // constrained random phase against the model
        do_reset();
        for (int c = 0; c < 6000; c++) begin
            if ($urandom_range(11) == 0) olow = ~olow;
            if ($urandom_range(39) == 0) active = ~active;
            shrt    = ($urandom_range(59) == 0);
            bus_act = ($urandom_range(29) == 0);
            wake    = ($urandom_range(24) == 0);
            clr     = ($urandom_range(19) == 0);
            wr      = ($urandom_range(14) == 0);
            w_man   = 1'($urandom_range(1));
            w_off   = 1'($urandom_range(1));
            w_ien   = 1'($urandom_range(1));
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule